// File: doc/BRIEF.md
# External Interrupt Controller with Asynchronous Capture

This block watches a small group of external request pins plus one extra pin reserved for non-maskable requests. Each pin is turned into a sticky per-line flag, and the flags feed three outputs: a maskable request toward the CPU's interrupt controller, a separate non-maskable request, and a wake signal for the power manager. Software configures each line through a plain register port. The line can sense a level or an edge, with either polarity, with an optional glitch filter, and through either the clocked sampling path or an unclocked path.

In the clocked path a pin passes through a two-stage synchronizer and an optional filter before a level or edge decision is made. In the unclocked path the pin is compared with its active level directly. The wake output then responds with no clock at all, and the flag is captured on the next sampling edge. Edge settings are read as levels in that path, and the filter is bypassed. The non-maskable line is the highest bit of every register and has the same options as the other lines. It has its own enable, but no mask.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every configuration register and every flag reads zero, and `irq_o`, `nmi_o` and `wake_o` are low.
- R2: Writing ones to address 0 sets line enables, and writing ones to address 1 clears them. Both addresses read back the enable vector. A disabled line never sets its flag.
- R3: In clocked edge mode (MODE bit 0, address 6) with the filter off, EDGE bit 1 (address 7) selects rising and EDGE bit 0 selects falling. The opposite edge is ignored. A pin change made before sampling edge 1 is visible in the flags after edge 3.
- R4: In clocked level mode (MODE bit 1), LEVEL bit 1 (address 8) means active-high and LEVEL bit 0 means active-low. The flag is set on every cycle the synchronized pin is active, so it re-sets after a clear while the level holds.
- R5: With FILTER bit 1 (address 9) in clocked mode, a new pin level is accepted only after it has been sampled on three consecutive edges. A 2-cycle pulse is dropped, and an accepted change reaches the flags 3 cycles later than without the filter.
- R6: With ASYNC bit 1 (address 10), the line is active while the pin equals LEVEL (level mode) or EDGE (edge mode, read as a level). `wake_o` rises with no clock edge, the flag is set on the next sampling edge, and the FILTER bit has no effect.
- R7: Flags read at address 4. Writing ones to address 5 clears the matching flags, except that a flag whose line triggers in the same cycle stays set.
- R8: Writing ones to address 2 sets mask bits, and writing ones to address 3 clears them. Both addresses read back the mask vector. `irq_o` is high exactly when some maskable line has both its flag and its mask bit set.
- R9: The top bit (index NUM_LINES) is the non-maskable line. `nmi_o` follows its flag whatever its mask bit holds, and it never drives `irq_o`.
- R10: The configuration registers at addresses 6 to 10 read back the last value written to them.
- R11: `wake_o` is high while any flag is set or any enabled unclocked line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | NUM_LINES+1 | External request pins, top bit non-maskable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | NUM_LINES+1 | Write data, one bit per line |
| rdata_o | output | NUM_LINES+1 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Maskable request to interrupt controller |
| nmi_o | output | 1 | Non-maskable request |
| wake_o | output | 1 | Wake request, partly combinational |

## Verification
Most internal faults show up at the ports quickly. A stuck synchronizer or filter counter moves the flag away from edge 3 (unfiltered) or edge 6 (filtered) after a pin change, and a one-cycle check catches it. A wrong polarity or sense-mode decode sets a flag on the wrong transition or keeps it from re-setting after a clear.

A broken unclocked path is seen on `wake_o` within a fraction of a cycle, and in the flags after a single edge. A mask or non-maskable routing error shows up on `irq_o` and `nmi_o` in the same cycle as the flag.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_EN_SET   = 4'd0,
    RA_EN_CLR   = 4'd1,
    RA_MSK_SET  = 4'd2,
    RA_MSK_CLR  = 4'd3,
    RA_FLAGS    = 4'd4,
    RA_FLAG_CLR = 4'd5,
    RA_MODE     = 4'd6,
    RA_EDGE     = 4'd7,
    RA_LEVEL    = 4'd8,
    RA_FILT     = 4'd9,
    RA_ASYNC    = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/extint_sync.sv
// Per-line synchronizer with optional majority-free persistence filter.
module extint_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic filt_en_i,
  output logic clean_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   synced;
  logic                   filt_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
  end

  assign synced = chain_q[SYNC_STAGES-1];

  // Filtered level moves only after FILT_LEN consecutive differing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (synced == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_q <= synced;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clean_o = filt_en_i ? filt_q : synced;
endmodule

// File: rtl/extint_detect.sv
// Per-line trigger decision for the clocked and unclocked paths.
module extint_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic clean_i,
  input  logic en_i,
  input  logic level_mode_i,
  input  logic edge_pol_i,
  input  logic level_pol_i,
  input  logic async_i,
  output logic trig_o,
  output logic wake_o
);
  logic prev_q;
  logic async_pol;
  logic async_act;
  logic sync_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= clean_i;
  end

  // Unclocked path: an edge setting is read as the active level.
  assign async_pol = level_mode_i ? level_pol_i : edge_pol_i;
  assign async_act = (raw_i == async_pol);

  always_comb begin
    if (level_mode_i)    sync_act = (clean_i == level_pol_i);
    else if (edge_pol_i) sync_act = clean_i & ~prev_q;
    else                 sync_act = ~clean_i & prev_q;
  end

  assign trig_o = en_i & (async_i ? async_act : sync_act);
  assign wake_o = en_i & async_i & async_act;
endmodule

// File: rtl/extint_regs.sv
// Register file and sticky flags.
module extint_regs
  import extint_pkg::*;
#(
  parameter int NW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NW-1:0]     wdata_i,
  input  logic [NW-1:0]     trig_i,
  output logic [NW-1:0]     rdata_o,
  output logic [NW-1:0]     en_o,
  output logic [NW-1:0]     mask_o,
  output logic [NW-1:0]     mode_o,
  output logic [NW-1:0]     edge_o,
  output logic [NW-1:0]     level_o,
  output logic [NW-1:0]     filt_o,
  output logic [NW-1:0]     async_o,
  output logic [NW-1:0]     flags_o
);
  logic [NW-1:0] en_q, mask_q, mode_q, edge_q, level_q, filt_q, async_q, flags_q;
  logic [NW-1:0] clr_vec;

  assign clr_vec = (wr_en_i && addr_i == RA_FLAG_CLR) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      mode_q  <= '0;
      edge_q  <= '0;
      level_q <= '0;
      filt_q  <= '0;
      async_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        RA_EN_SET:  en_q    <= en_q | wdata_i;
        RA_EN_CLR:  en_q    <= en_q & ~wdata_i;
        RA_MSK_SET: mask_q  <= mask_q | wdata_i;
        RA_MSK_CLR: mask_q  <= mask_q & ~wdata_i;
        RA_MODE:    mode_q  <= wdata_i;
        RA_EDGE:    edge_q  <= wdata_i;
        RA_LEVEL:   level_q <= wdata_i;
        RA_FILT:    filt_q  <= wdata_i;
        RA_ASYNC:   async_q <= wdata_i;
        default:    ;
      endcase
    end
  end

  // A new trigger wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | trig_i;
  end

  always_comb begin
    case (addr_i)
      RA_EN_SET, RA_EN_CLR:   rdata_o = en_q;
      RA_MSK_SET, RA_MSK_CLR: rdata_o = mask_q;
      RA_FLAGS:               rdata_o = flags_q;
      RA_MODE:                rdata_o = mode_q;
      RA_EDGE:                rdata_o = edge_q;
      RA_LEVEL:               rdata_o = level_q;
      RA_FILT:                rdata_o = filt_q;
      RA_ASYNC:               rdata_o = async_q;
      default:                rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign edge_o  = edge_q;
  assign level_o = level_q;
  assign filt_o  = filt_q;
  assign async_o = async_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES:0]   pin_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES:0]   wdata_i,
  output logic [NUM_LINES:0]   rdata_o,
  output logic                 irq_o,
  output logic                 nmi_o,
  output logic                 wake_o
);
  localparam int NW  = NUM_LINES + 1;
  localparam int NMI = NUM_LINES;

  logic [NW-1:0] en_q, mask_q, mode_q, edge_q, level_q, filt_q, async_q, flags_q;
  logic [NW-1:0] clean_vec, trig_vec, wake_vec;

  extint_regs #(.NW(NW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .trig_i(trig_vec), .rdata_o(rdata_o),
    .en_o(en_q), .mask_o(mask_q), .mode_o(mode_q), .edge_o(edge_q),
    .level_o(level_q), .filt_o(filt_q), .async_o(async_q), .flags_o(flags_q)
  );

  for (genvar i = 0; i < NW; i++) begin : g_line
    extint_sync #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i[i]),
      .filt_en_i(filt_q[i]), .clean_o(clean_vec[i])
    );
    extint_detect u_det (
      .clk(clk), .rst_n(rst_n), .raw_i(pin_i[i]), .clean_i(clean_vec[i]),
      .en_i(en_q[i]), .level_mode_i(mode_q[i]), .edge_pol_i(edge_q[i]),
      .level_pol_i(level_q[i]), .async_i(async_q[i]),
      .trig_o(trig_vec[i]), .wake_o(wake_vec[i])
    );
  end

  assign irq_o  = |(flags_q[NUM_LINES-1:0] & mask_q[NUM_LINES-1:0]);
  assign nmi_o  = flags_q[NMI];
  assign wake_o = (|wake_vec) | (|flags_q);
endmodule

// File: rtl/extint_sva.sv
module extint_sva
  import extint_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES:0]   pin_i,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 irq_o,
  input logic                 wake_o,
  input logic [NUM_LINES:0]   flags_q,
  input logic [NUM_LINES:0]   en_q,
  input logic [NUM_LINES:0]   mask_q,
  input logic [NUM_LINES:0]   mode_q,
  input logic [NUM_LINES:0]   edge_q,
  input logic [NUM_LINES:0]   level_q,
  input logic [NUM_LINES:0]   async_q
);
  logic [NUM_LINES:0] pol_vec, async_live;
  assign pol_vec    = (mode_q & level_q) | (~mode_q & edge_q);
  assign async_live = en_q & async_q & ~(pin_i ^ pol_vec);

  a_r2_off_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(en_q)) == '0));

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == RA_FLAG_CLR) |=> ((~flags_q & $past(flags_q)) == '0));

  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q[NUM_LINES-1:0] != '0));

  a_r9_nmi_not_in_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_q[NUM_LINES-1:0] != '0));

  a_r11_wake_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0) |-> wake_o);

  a_r6_wake_now: assert property (@(posedge clk) disable iff (!rst_n)
    (async_live != '0) |-> wake_o);

  a_r6_flag_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (async_live != '0) |=> ((flags_q & $past(async_live)) == $past(async_live)));
endmodule

bind extint_ctrl extint_sva #(.NUM_LINES(NUM_LINES)) u_sva (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .irq_o(irq_o), .wake_o(wake_o), .flags_q(flags_q), .en_q(en_q),
  .mask_q(mask_q), .mode_q(mode_q), .edge_q(edge_q), .level_q(level_q),
  .async_q(async_q)
);

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int NW = NL + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] pin_i = '0;
  logic          wr_en_i = 1'b0;
  logic [3:0]    addr_i = '0;
  logic [NW-1:0] wdata_i = '0;
  logic [NW-1:0] rdata_o;
  logic          irq_o, nmi_o, wake_o;

  int n_run = 0;
  int n_fail = 0;
  logic [NW-1:0] mode_s = '0, edge_s = '0, lvl_s = '0, filt_s = '0, async_s = '0;

  extint_ctrl #(.NUM_LINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .nmi_o(nmi_o), .wake_o(wake_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [NW-1:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NW-1:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic flag(input int i, input logic exp, input string tag);
    logic [NW-1:0] d;
    rd(4'd4, d);
    chk(32'(d[i]), 32'(exp), tag);
  endtask

  task automatic push_cfg();
    wr(4'd6, mode_s); wr(4'd7, edge_s); wr(4'd8, lvl_s);
    wr(4'd9, filt_s); wr(4'd10, async_s);
  endtask

  task automatic t_reset();
    logic [NW-1:0] d;
    for (int a = 0; a <= 10; a++) begin
      rd(4'(a), d);
      chk(32'(d), 0, "R1 reset register");
    end
    chk(32'({irq_o, nmi_o, wake_o}), 0, "R1 outputs low");
  endtask

  task automatic t_readback();
    logic [NW-1:0] d;
    wr(4'd6, 5'b10101); rd(4'd6, d); chk(32'(d), 32'h15, "R10 mode readback");
    wr(4'd10, 5'b01010); rd(4'd10, d); chk(32'(d), 32'h0a, "R10 async readback");
    wr(4'd6, '0); wr(4'd10, '0);
    wr(4'd0, 5'b00011); rd(4'd1, d); chk(32'(d), 32'h03, "R2 enable set");
    wr(4'd1, 5'b00011); rd(4'd0, d); chk(32'(d), 0, "R2 enable clear");
    wr(4'd2, 5'b00110); wr(4'd3, 5'b00100); rd(4'd2, d); chk(32'(d), 32'h02, "R8 mask set/clear");
    wr(4'd3, '1);
  endtask

  task automatic t_sync_rise();
    edge_s[0] = 1'b1; push_cfg();
    wr(4'd0, 5'b00001); wr(4'd2, 5'b00001);
    pin_i[0] = 1'b1;
    tick(2); flag(0, 1'b0, "R3 rise not before edge 3");
    chk(32'(irq_o), 0, "R8 irq low before flag");
    tick(1); flag(0, 1'b1, "R3 rise at edge 3");
    chk(32'(irq_o), 1, "R8 irq masked-in flag");
    chk(32'(wake_o), 1, "R11 wake on pending flag");
    wr(4'd5, 5'b00001); flag(0, 1'b0, "R7 clear");
    chk(32'(irq_o), 0, "R8 irq drops after clear");
    pin_i[0] = 1'b0;
    tick(4); flag(0, 1'b0, "R3 falling ignored in rise mode");
    wr(4'd3, 5'b00001);
  endtask

  task automatic t_sync_fall();
    edge_s[1] = 1'b0; push_cfg();
    wr(4'd0, 5'b00010);
    pin_i[1] = 1'b1;
    tick(4); flag(1, 1'b0, "R3 rise ignored in fall mode");
    pin_i[1] = 1'b0;
    tick(2); flag(1, 1'b0, "R3 fall not before edge 3");
    tick(1); flag(1, 1'b1, "R3 fall at edge 3");
    chk(32'(irq_o), 0, "R8 unmasked flag gives no irq");
    wr(4'd5, 5'b00010);
  endtask

  task automatic t_level();
    mode_s[2] = 1'b1; lvl_s[2] = 1'b1; push_cfg();
    wr(4'd0, 5'b00100);
    pin_i[2] = 1'b1;
    tick(2); flag(2, 1'b0, "R4 high level not yet");
    tick(1); flag(2, 1'b1, "R4 high level sets");
    wr(4'd5, 5'b00100); flag(2, 1'b1, "R7 set wins over clear while held");
    pin_i[2] = 1'b0;
    tick(3); wr(4'd5, 5'b00100);
    tick(3); flag(2, 1'b0, "R4 inactive level stays clear");
    lvl_s[2] = 1'b0; wr(4'd8, lvl_s);
    tick(1); flag(2, 1'b1, "R4 low level sets");
    wr(4'd1, 5'b00100); wr(4'd5, 5'b00100);
    tick(3); flag(2, 1'b0, "R2 disabled level line stays clear");
    mode_s[2] = 1'b0; wr(4'd6, mode_s);
  endtask

  task automatic t_filter();
    filt_s[0] = 1'b1; push_cfg();
    wr(4'd0, 5'b00001);
    pin_i[0] = 1'b1; tick(2); pin_i[0] = 1'b0;
    tick(6); flag(0, 1'b0, "R5 two-cycle pulse dropped");
    pin_i[0] = 1'b1;
    tick(5); flag(0, 1'b0, "R5 not accepted before edge 6");
    tick(1); flag(0, 1'b1, "R5 accepted at edge 6");
    pin_i[0] = 1'b0; tick(8); wr(4'd5, 5'b00001);
    wr(4'd1, 5'b00001); filt_s[0] = 1'b0; wr(4'd9, filt_s);
  endtask

  task automatic t_disabled();
    edge_s[3] = 1'b1; push_cfg();
    pin_i[3] = 1'b1; tick(4); pin_i[3] = 1'b0; tick(4);
    flag(3, 1'b0, "R2 disabled line never flags");
  endtask

  task automatic t_async();
    async_s[1] = 1'b1; filt_s[1] = 1'b1; edge_s[1] = 1'b1; push_cfg();
    wr(4'd0, 5'b00010);
    tick(2); wr(4'd5, '1);
    pin_i[1] = 1'b1;
    #1 chk(32'(wake_o), 1, "R6 wake without clock");
    flag(1, 1'b0, "R6 flag waits for edge");
    tick(1); flag(1, 1'b1, "R6 flag on next edge, filter ignored");
    wr(4'd5, 5'b00010); flag(1, 1'b1, "R6 edge setting acts as level");
    pin_i[1] = 1'b0;
    wr(4'd5, 5'b00010);
    flag(1, 1'b0, "R7 clear after release");
    chk(32'(wake_o), 0, "R11 wake low when idle");
    edge_s[1] = 1'b0; wr(4'd7, edge_s);
    #1 chk(32'(wake_o), 1, "R6 edge bit 0 means active low");
    flag(1, 1'b0, "R6 active-low flag waits");
    tick(1); flag(1, 1'b1, "R6 active-low flag set");
    wr(4'd1, 5'b00010); async_s = '0; filt_s = '0; push_cfg();
    wr(4'd5, '1);
    tick(1); flag(1, 1'b0, "R6 cleanup");
  endtask

  task automatic t_nmi();
    edge_s[NL] = 1'b1; push_cfg();
    wr(4'd0, 5'b10000); wr(4'd2, 5'b10000); wr(4'd3, 5'b10000);
    pin_i[NL] = 1'b1;
    tick(3);
    chk(32'(nmi_o), 1, "R9 nmi raised without mask");
    chk(32'(irq_o), 0, "R9 nmi does not drive irq");
    wr(4'd5, 5'b10000);
    chk(32'(nmi_o), 0, "R9 nmi cleared");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_run++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_readback();
    t_sync_rise();
    t_sync_fall();
    t_level();
    t_filter();
    t_disabled();
    t_async();
    t_nmi();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule